// File: doc/BRIEF.md
# Effective Address Operand Unit

This block turns a six-bit operand specifier (a three-bit mode and a three-bit register field) into a complete operand access for a small CISC core. The core has eight data registers and eight address registers, and the unit holds both banks. It takes an operand size of byte, word or long, a read or write request, and the data to be written. From these it performs one of three kinds of access: a register access, a memory access through an address register, or an access that first fetches extension words from the instruction stream.

Memory traffic goes over a simple request/ready bus, and only one transaction is in flight at a time. Extension words are fetched at the current PC plus the current instruction length. When the operation ends, the unit pulses `done_o` for one cycle. In that cycle it presents the operand read (or, for the PC-relative form, the computed address), the number of extension bytes it consumed, and an illegal-operand flag.

The core starts one operation at a time and waits for `done_o` before it starts the next. The contents of any register can be read back by a register-direct read.

Top module: `ea_operand_unit`

## Requirements
- R1: Reset clears all sixteen registers to zero and drives `busy_o`, `done_o` and `mem_req_o` low.
- R2: Mode 0 accesses data register n and mode 1 accesses address register n, which is entry 8+n of the register file. A byte write replaces only bits 7:0, a word write only bits 15:0, and a long write all 32 bits. A read returns the register value truncated to the size. Neither mode touches the bus.
- R3: Mode 2 makes one data access at the address held in address register n and leaves that register unchanged.
- R4: Mode 3 makes one data access at address register n. In the cycle the bus handshake completes, it then adds the step to the register: 1 for byte, 2 for word, 4 for long.
- R5: Mode 4 subtracts the step from address register n, makes the data access at the decremented value, and writes that value back to the register.
- R6: In modes 3 and 4, when the register is address register 7 and the size is byte, the step is 2.
- R7: Mode 5 fetches one 16-bit extension word, sign-extends it, and adds it to address register n to form the data address. It reports 2 extension bytes.
- R8: Mode 7 with register 0 fetches a 16-bit address and sign-extends it to 32 bits (2 extension bytes). Mode 7 with register 1 fetches a 32-bit address (4 extension bytes). Each then makes one data access at that address.
- R9: Mode 7 with register 2 is a read that fetches a 16-bit displacement and returns PC + sign-extended displacement + 2 as the result, with no data access (2 extension bytes). A write in this mode is illegal.
- R10: Mode 7 with register 4 is an immediate read. Byte and word sizes fetch one word (2 extension bytes), and long fetches 32 bits (4 extension bytes). The result is the fetched value truncated to the size. A write in this mode is illegal.
- R11: Mode 6, mode 7 with register 3 or 5 to 7, size code 3, and writes in modes 7/2 and 7/4 set `illegal_o`. Such an operation makes no bus access, reports 0 extension bytes and changes no register.
- R12: Once `mem_req_o` is raised, address and control hold steady until `mem_ready_i`, and only one transaction is outstanding at a time. Extension fetches raise `mem_fetch_o` and use address `pc_i + len_i`.
- R13: Size codes are 0 = byte, 1 = word, 2 = long, on both `size_i` and `mem_size_o`. Bus data is right-aligned. Data read from memory is zero-extended above the operand size, and write data is truncated to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| write_i | input | 1 | 1 = write operand, 0 = read |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register field |
| size_i | input | 2 | Operand size code |
| wdata_i | input | 32 | Data to write |
| pc_i | input | 32 | Current instruction address |
| len_i | input | LEN_W | Instruction bytes consumed so far |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal operand specifier (valid with done) |
| result_o | output | 32 | Operand or computed address (valid with done) |
| ext_bytes_o | output | 3 | Extension bytes consumed (valid with done) |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write enable |
| mem_fetch_o | output | 1 | Request is an instruction-stream fetch |
| mem_size_o | output | 2 | Bus transfer size code |
| mem_addr_o | output | 32 | Bus address |
| mem_wdata_o | output | 32 | Bus write data, right-aligned |
| mem_rdata_i | input | 32 | Bus read data, right-aligned |
| mem_ready_i | input | 1 | Bus handshake complete |

## Verification
The hardest case to reach from the ports is a mode that chains two bus transactions: an extension fetch whose handshake immediately launches the data access. The request line then stays high across the boundary while the address and control change under it. The bench inserts a configurable number of wait states before each ready, so that both transactions of a chain have to hold still while stalled. It logs fetch and data accesses separately, so it can check both the address of each access and the number of accesses per operation. Register side effects of post-increment and pre-decrement are read back through register-direct reads, including the byte step on address register 7.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    typedef enum logic [2:0] {
        EA_DREG    = 3'd0,
        EA_AREG    = 3'd1,
        EA_IND     = 3'd2,
        EA_POST    = 3'd3,
        EA_PRE     = 3'd4,
        EA_DISP    = 3'd5,
        EA_INDEX   = 3'd6,
        EA_SPECIAL = 3'd7
    } ea_mode_e;

    // register-field codes used under EA_SPECIAL
    localparam logic [2:0] SP_ABS16 = 3'd0;
    localparam logic [2:0] SP_ABS32 = 3'd1;
    localparam logic [2:0] SP_PCREL = 3'd2;
    localparam logic [2:0] SP_IMM   = 3'd4;

    typedef enum logic [2:0] {
        CL_REG,     // register direct
        CL_MEM,     // memory through address register, no extension
        CL_EXTMEM,  // extension fetch, then data access
        CL_EXTVAL,  // extension fetch supplies the result
        CL_BAD      // unsupported specifier
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_DATA,
        ST_FIN
    } ea_state_e;

    typedef struct packed {
        ea_mode_e             mode;
        logic [2:0]           rsel;
        opsize_e              size;
        logic                 write;
        logic [XLEN-1:0]      wdata;
        logic [XLEN-1:0]      pc;
    } op_req_t;

    function automatic logic [2:0] size_bytes(opsize_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] fit(opsize_e sz, logic [XLEN-1:0] v);
        case (sz)
            SZ_BYTE: return {{(XLEN-8){1'b0}},  v[7:0]};
            SZ_WORD: return {{(XLEN-16){1'b0}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] merge(opsize_e sz, logic [XLEN-1:0] old_v,
                                              logic [XLEN-1:0] new_v);
        case (sz)
            SZ_BYTE: return {old_v[XLEN-1:8],  new_v[7:0]};
            SZ_WORD: return {old_v[XLEN-1:16], new_v[15:0]};
            default: return new_v;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext16(logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic op_class_e classify(ea_mode_e m, logic [2:0] r, opsize_e sz, logic wr);
        if (sz == SZ_RSVD) return CL_BAD;
        case (m)
            EA_DREG, EA_AREG:       return CL_REG;
            EA_IND, EA_POST, EA_PRE: return CL_MEM;
            EA_DISP:                return CL_EXTMEM;
            EA_SPECIAL: begin
                if (r == SP_ABS16 || r == SP_ABS32) return CL_EXTMEM;
                if (r == SP_PCREL || r == SP_IMM)   return wr ? CL_BAD : CL_EXTVAL;
                return CL_BAD;
            end
            default:                return CL_BAD;
        endcase
    endfunction

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile
    import ea_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [XLEN-1:0]   rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  opsize_e           wr_size,
    input  logic [XLEN-1:0]   wr_data
);

    logic [XLEN-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wr_idx == IDX_W'(g)) begin
                regs[g] <= merge(wr_size, regs[g], wr_data);
            end
        end
    end

    assign rd_data = regs[rd_idx];

    // R2
    byte_keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_size == SZ_BYTE) |=>
            (regs[$past(wr_idx)][XLEN-1:8] == $past(regs[wr_idx][XLEN-1:8])));

    // R2
    word_keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_size == SZ_WORD) |=>
            (regs[$past(wr_idx)][XLEN-1:16] == $past(regs[wr_idx][XLEN-1:16])));

endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
    import ea_pkg::*;
(
    input  ea_mode_e         mode,
    input  logic [2:0]       rsel,
    input  opsize_e          size,
    input  logic [XLEN-1:0]  areg,
    input  logic [XLEN-1:0]  ext,
    input  logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  base_addr,
    output logic [XLEN-1:0]  ext_addr,
    output logic [XLEN-1:0]  pcrel_val,
    output logic [XLEN-1:0]  post_val,
    output logic [XLEN-1:0]  pre_val
);

    localparam logic [2:0] STACK_REG = 3'd7;

    logic [2:0] step;

    always_comb begin
        step = size_bytes(size);
        if (rsel == STACK_REG && size == SZ_BYTE) step = 3'd2;
    end

    assign post_val  = areg + XLEN'(step);
    assign pre_val   = areg - XLEN'(step);
    assign base_addr = (mode == EA_PRE) ? pre_val : areg;
    assign pcrel_val = pc + sext16(ext[15:0]) + XLEN'(2);

    always_comb begin
        ext_addr = areg + sext16(ext[15:0]);
        if (mode == EA_SPECIAL) begin
            if (rsel == SP_ABS32) ext_addr = ext;
            else                  ext_addr = sext16(ext[15:0]);
        end
    end

endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
    import ea_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int NUM_DREG = 8,
    parameter int NUM_AREG = 8,
    localparam int NREGS   = NUM_DREG + NUM_AREG,
    localparam int IDX_W   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [2:0]        mode_i,
    input  logic [2:0]        reg_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       wdata_i,
    input  logic [31:0]       pc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [31:0]       result_o,
    output logic [2:0]        ext_bytes_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_fetch_o,
    output logic [1:0]        mem_size_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ready_i
);

    ea_state_e        state;
    op_req_t          op_in, op_q;
    op_class_e        cls_in;

    logic [XLEN-1:0]  result_q;
    logic [2:0]       extb_q;
    logic             illegal_q;
    logic             mem_req_q, mem_we_q, mem_fetch_q;
    opsize_e          mem_size_q;
    logic [XLEN-1:0]  mem_addr_q, mem_wdata_q;

    ea_mode_e         m_act;
    logic [2:0]       rsel_act;
    opsize_e          size_act;
    logic [IDX_W-1:0] rd_idx;
    logic [XLEN-1:0]  rf_rdata;

    logic             rf_we;
    logic [IDX_W-1:0] rf_widx;
    opsize_e          rf_wsize;
    logic [XLEN-1:0]  rf_wdata;

    logic [XLEN-1:0]  ext_val;
    logic [XLEN-1:0]  base_addr, ext_addr, pcrel_val, post_val, pre_val;
    logic             ext_long_in;

    always_comb begin
        op_in.mode  = ea_mode_e'(mode_i);
        op_in.rsel  = reg_i;
        op_in.size  = opsize_e'(size_i);
        op_in.write = write_i;
        op_in.wdata = wdata_i;
        op_in.pc    = pc_i;
    end

    assign cls_in = classify(op_in.mode, op_in.rsel, op_in.size, op_in.write);

    assign ext_long_in = (op_in.mode == EA_SPECIAL) &&
                         ((op_in.rsel == SP_ABS32) ||
                          (op_in.rsel == SP_IMM && op_in.size == SZ_LONG));

    // operand fields in use: live inputs while idle, latched copy afterwards
    assign m_act    = (state == ST_IDLE) ? op_in.mode : op_q.mode;
    assign rsel_act = (state == ST_IDLE) ? op_in.rsel : op_q.rsel;
    assign size_act = (state == ST_IDLE) ? op_in.size : op_q.size;
    assign rd_idx   = (m_act == EA_DREG) ? IDX_W'(rsel_act)
                                         : IDX_W'(rsel_act) + IDX_W'(NUM_DREG);

    assign ext_val  = fit(mem_size_q, mem_rdata_i);

    always_comb begin
        rf_we    = 1'b0;
        rf_widx  = rd_idx;
        rf_wsize = SZ_LONG;
        rf_wdata = '0;
        if (state == ST_IDLE && start_i && cls_in == CL_REG && op_in.write) begin
            rf_we    = 1'b1;
            rf_wsize = op_in.size;
            rf_wdata = op_in.wdata;
        end else if (state == ST_DATA && mem_ready_i &&
                     (op_q.mode == EA_POST || op_q.mode == EA_PRE)) begin
            rf_we    = 1'b1;
            rf_wdata = (op_q.mode == EA_POST) ? post_val : pre_val;
        end
    end

    ea_regfile #(.NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_data (rf_rdata),
        .we      (rf_we),
        .wr_idx  (rf_widx),
        .wr_size (rf_wsize),
        .wr_data (rf_wdata)
    );

    ea_addr_unit u_addr (
        .mode      (m_act),
        .rsel      (rsel_act),
        .size      (size_act),
        .areg      (rf_rdata),
        .ext       (ext_val),
        .pc        (op_q.pc),
        .base_addr (base_addr),
        .ext_addr  (ext_addr),
        .pcrel_val (pcrel_val),
        .post_val  (post_val),
        .pre_val   (pre_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            op_q        <= '0;
            result_q    <= '0;
            extb_q      <= '0;
            illegal_q   <= 1'b0;
            mem_req_q   <= 1'b0;
            mem_we_q    <= 1'b0;
            mem_fetch_q <= 1'b0;
            mem_size_q  <= SZ_BYTE;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q      <= op_in;
                        result_q  <= '0;
                        extb_q    <= '0;
                        illegal_q <= 1'b0;
                        case (cls_in)
                            CL_REG: begin
                                result_q <= op_in.write ? fit(op_in.size, op_in.wdata)
                                                        : fit(op_in.size, rf_rdata);
                                state    <= ST_FIN;
                            end
                            CL_MEM: begin
                                mem_req_q   <= 1'b1;
                                mem_we_q    <= op_in.write;
                                mem_fetch_q <= 1'b0;
                                mem_size_q  <= op_in.size;
                                mem_addr_q  <= base_addr;
                                mem_wdata_q <= fit(op_in.size, op_in.wdata);
                                state       <= ST_DATA;
                            end
                            CL_EXTMEM, CL_EXTVAL: begin
                                mem_req_q   <= 1'b1;
                                mem_we_q    <= 1'b0;
                                mem_fetch_q <= 1'b1;
                                mem_size_q  <= ext_long_in ? SZ_LONG : SZ_WORD;
                                mem_addr_q  <= pc_i + XLEN'(len_i);
                                state       <= ST_EXT;
                            end
                            default: begin
                                illegal_q <= 1'b1;
                                state     <= ST_FIN;
                            end
                        endcase
                    end
                end
                ST_EXT: begin
                    if (mem_ready_i) begin
                        extb_q <= (mem_size_q == SZ_LONG) ? 3'd4 : 3'd2;
                        if (op_q.mode == EA_SPECIAL && op_q.rsel == SP_PCREL) begin
                            result_q  <= pcrel_val;
                            mem_req_q <= 1'b0;
                            state     <= ST_FIN;
                        end else if (op_q.mode == EA_SPECIAL && op_q.rsel == SP_IMM) begin
                            result_q  <= fit(op_q.size, ext_val);
                            mem_req_q <= 1'b0;
                            state     <= ST_FIN;
                        end else begin
                            mem_we_q    <= op_q.write;
                            mem_fetch_q <= 1'b0;
                            mem_size_q  <= op_q.size;
                            mem_addr_q  <= ext_addr;
                            mem_wdata_q <= fit(op_q.size, op_q.wdata);
                            state       <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (mem_ready_i) begin
                        mem_req_q <= 1'b0;
                        result_q  <= op_q.write ? mem_wdata_q : fit(op_q.size, mem_rdata_i);
                        state     <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_FIN);
    assign illegal_o   = illegal_q;
    assign result_o    = result_q;
    assign ext_bytes_o = extb_q;
    assign mem_req_o   = mem_req_q;
    assign mem_we_o    = mem_we_q;
    assign mem_fetch_o = mem_fetch_q;
    assign mem_size_o  = mem_size_q;
    assign mem_addr_o  = mem_addr_q;
    assign mem_wdata_o = mem_wdata_q;

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
             $stable(mem_size_o) && $stable(mem_fetch_o)));

    // R12
    done_no_txn_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o);

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_i && cls_in == CL_BAD) |=>
            (done_o && illegal_o && !mem_req_o && ext_bytes_o == 3'd0));

    // R6
    sp_byte_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && mem_ready_i && op_q.mode == EA_POST &&
         op_q.rsel == 3'd7 && op_q.size == SZ_BYTE) |=>
            (rf_rdata == $past(rf_rdata) + 32'd2));

    // R9
    pcrel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q.write && op_q.mode == EA_SPECIAL && op_q.rsel == SP_PCREL)
            |-> illegal_o);

endmodule

// File: tb/tb_ea_operand_unit.sv
module tb_ea_operand_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, wr = 1'b0;
    logic [2:0]  mode = '0, rsel = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0, pc = '0;
    logic [3:0]  len = '0;
    logic        busy, done, illegal;
    logic [31:0] result;
    logic [2:0]  ext_bytes;
    logic        mem_req, mem_we, mem_fetch;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;

    ea_operand_unit dut (
        .clk(clk), .rst(rst), .start_i(start), .write_i(wr), .mode_i(mode),
        .reg_i(rsel), .size_i(size), .wdata_i(wdata), .pc_i(pc), .len_i(len),
        .busy_o(busy), .done_o(done), .illegal_o(illegal), .result_o(result),
        .ext_bytes_o(ext_bytes), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_fetch_o(mem_fetch), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
    );

    localparam logic [1:0] B = 2'd0, W = 2'd1, L = 2'd2;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    // memory model, big-endian bytes, data right-aligned on the bus
    logic [7:0]  mem [0:4095];
    int          wait_cycles = 0, wcnt = 0;
    int          data_cnt = 0, fetch_cnt = 0;
    logic [31:0] last_addr = '0, last_fetch_addr = '0;
    logic        last_we = 1'b0;
    logic [1:0]  last_fetch_size = '0;

    function automatic int nbytes(logic [1:0] s);
        return (s == B) ? 1 : (s == W) ? 2 : 4;
    endfunction

    function automatic logic [31:0] peek(logic [31:0] a, int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 32'(mem[12'(a + 32'(i))]);
        return v;
    endfunction

    task automatic poke(logic [31:0] a, logic [31:0] v, int n);
        for (int i = 0; i < n; i++) mem[12'(a + 32'(i))] = 8'(v >> (8 * (n - 1 - i)));
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            wcnt = 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cycles) begin
                if (mem_we) poke(mem_addr, mem_wdata, nbytes(mem_size));
                else        mem_rdata <= peek(mem_addr, nbytes(mem_size));
                if (mem_fetch) begin
                    fetch_cnt++;
                    last_fetch_addr = mem_addr;
                    last_fetch_size = mem_size;
                end else begin
                    data_cnt++;
                    last_addr = mem_addr;
                    last_we   = mem_we;
                end
                mem_ready <= 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [31:0] res;
    logic        ill;
    logic [2:0]  extb;
    int          acc_d, acc_f;

    task automatic op(logic [2:0] m, logic [2:0] r, logic [1:0] sz, logic w, logic [31:0] wd);
        int d0 = data_cnt, f0 = fetch_cnt;
        bit got = 0;
        @(negedge clk);
        start = 1'b1; mode = m; rsel = r; size = sz; wr = w; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        if (!got) begin
            n_chk++; n_fail++;
            $display("FAIL R12 op timeout act=busy exp=done");
        end
        res = result; ill = illegal; extb = ext_bytes;
        acc_d = data_cnt - d0; acc_f = fetch_cnt - f0;
    endtask

    task automatic set_reg(bit is_a, logic [2:0] r, logic [31:0] v);
        op(is_a ? 3'd1 : 3'd0, r, L, 1'b1, v);
    endtask

    task automatic get_reg(bit is_a, logic [2:0] r, output logic [31:0] v);
        op(is_a ? 3'd1 : 3'd0, r, L, 1'b0, '0);
        v = res;
    endtask

    logic [31:0] rv;

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        get_reg(0, 3'd0, rv); chk("R1 D0", rv, 0);
        get_reg(1, 3'd7, rv); chk("R1 A7", rv, 0);
    endtask

    task automatic t_regs();
        set_reg(0, 3'd3, 32'h11223344);
        op(0, 3'd3, B, 1, 32'hFFFF_FFAB);
        get_reg(0, 3'd3, rv); chk("R2 byte merge", rv, 32'h112233AB);
        op(0, 3'd3, W, 1, 32'h0000BEEF);
        get_reg(0, 3'd3, rv); chk("R2 word merge", rv, 32'h1122BEEF);
        op(0, 3'd3, B, 0, '0); chk("R2 byte read", res, 32'h000000EF);
        chk("R2 no bus", 32'(acc_d + acc_f), 0);
        set_reg(1, 3'd2, 32'h100);
        get_reg(0, 3'd2, rv); chk("R2 areg offset D2", rv, 0);
        get_reg(1, 3'd2, rv); chk("R2 A2", rv, 32'h100);
    endtask

    task automatic t_indirect();
        poke(32'h100, 32'hCAFEF00D, 4);
        op(2, 3'd2, L, 0, '0);
        chk("R3 data", res, 32'hCAFEF00D);
        chk("R3 addr", last_addr, 32'h100);
        chk("R3 one access", 32'(acc_d), 1);
        op(2, 3'd2, W, 0, '0);
        chk("R13 word zero-ext", res, 32'h0000CAFE);
        get_reg(1, 3'd2, rv); chk("R3 A2 kept", rv, 32'h100);
    endtask

    task automatic t_postinc();
        wait_cycles = 2;
        set_reg(1, 3'd3, 32'h200);
        op(3, 3'd3, B, 0, '0); chk("R4 byte addr", last_addr, 32'h200);
        get_reg(1, 3'd3, rv);  chk("R4 +1", rv, 32'h201);
        op(3, 3'd3, W, 0, '0); chk("R4 word addr", last_addr, 32'h201);
        get_reg(1, 3'd3, rv);  chk("R4 +2", rv, 32'h203);
        op(3, 3'd3, L, 0, '0); chk("R4 long addr", last_addr, 32'h203);
        get_reg(1, 3'd3, rv);  chk("R4 +4", rv, 32'h207);
        op(3, 3'd3, W, 1, 32'hABCD1234);
        chk("R13 write trunc", peek(32'h207, 2), 32'h1234);
        chk("R13 byte after", peek(32'h209, 1), 32'h00);
        get_reg(1, 3'd3, rv);  chk("R4 write +2", rv, 32'h209);
        wait_cycles = 0;
    endtask

    task automatic t_predec();
        set_reg(1, 3'd4, 32'h300);
        op(4, 3'd4, L, 1, 32'h55667788);
        chk("R5 addr", last_addr, 32'h2FC);
        chk("R5 we", 32'(last_we), 1);
        chk("R5 mem", peek(32'h2FC, 4), 32'h55667788);
        get_reg(1, 3'd4, rv); chk("R5 A4", rv, 32'h2FC);
        poke(32'h2FB, 32'h9A, 1);
        op(4, 3'd4, B, 0, '0);
        chk("R5 byte data", res, 32'h9A);
        get_reg(1, 3'd4, rv); chk("R5 A4 -1", rv, 32'h2FB);
    endtask

    task automatic t_stack();
        set_reg(1, 3'd7, 32'h400);
        op(3, 3'd7, B, 0, '0);
        get_reg(1, 3'd7, rv); chk("R6 A7 post +2", rv, 32'h402);
        op(4, 3'd7, B, 1, 32'h5C);
        chk("R6 A7 pre addr", last_addr, 32'h400);
        chk("R6 mem", peek(32'h400, 1), 32'h5C);
        get_reg(1, 3'd7, rv); chk("R6 A7 pre -2", rv, 32'h400);
        set_reg(1, 3'd6, 32'h410);
        op(3, 3'd6, B, 0, '0);
        get_reg(1, 3'd6, rv); chk("R6 A6 step 1", rv, 32'h411);
    endtask

    task automatic t_disp();
        wait_cycles = 3;
        pc = 32'h40; len = 4'd2;
        poke(32'h42, 32'hFFF0, 2);
        poke(32'h4F0, 32'h0BADBEEF, 4);
        set_reg(1, 3'd5, 32'h500);
        op(5, 3'd5, L, 0, '0);
        chk("R7 data", res, 32'h0BADBEEF);
        chk("R7 ext bytes", 32'(extb), 2);
        chk("R7 legal", 32'(ill), 0);
        chk("R12 fetch addr", last_fetch_addr, 32'h42);
        chk("R7 data addr", last_addr, 32'h4F0);
        chk("R12 accesses", 32'(acc_d * 10 + acc_f), 11);
        get_reg(1, 3'd5, rv); chk("R7 A5 kept", rv, 32'h500);
        wait_cycles = 0;
    endtask

    task automatic t_abs();
        pc = 32'h80; len = 4'd4;
        poke(32'h84, 32'h0120, 2);
        poke(32'h120, 32'hA5A5, 2);
        op(7, 3'd0, W, 0, '0);
        chk("R8 abs16 data", res, 32'hA5A5);
        chk("R8 abs16 ext", 32'(extb), 2);
        chk("R12 abs fetch addr", last_fetch_addr, 32'h84);
        poke(32'h84, 32'h8010, 2);
        op(7, 3'd0, B, 1, 32'h77);
        chk("R8 abs16 sext addr", last_addr, 32'hFFFF8010);
        chk("R8 abs16 write", peek(32'h010, 1), 32'h77);
        poke(32'h84, 32'h00000800, 4);
        poke(32'h800, 32'h13579BDF, 4);
        op(7, 3'd1, L, 0, '0);
        chk("R8 abs32 data", res, 32'h13579BDF);
        chk("R8 abs32 ext", 32'(extb), 4);
        chk("R8 abs32 fetch size", 32'(last_fetch_size), 32'(L));
    endtask

    task automatic t_pcrel();
        pc = 32'h40; len = 4'd2;
        poke(32'h42, 32'hFFFE, 2);
        op(7, 3'd2, L, 0, '0);
        chk("R9 neg disp", res, 32'h40);
        chk("R9 ext", 32'(extb), 2);
        chk("R9 no data access", 32'(acc_d * 10 + acc_f), 1);
        poke(32'h42, 32'h0010, 2);
        op(7, 3'd2, W, 0, '0);
        chk("R9 pos disp", res, 32'h52);
        op(7, 3'd2, L, 1, 32'h1);
        chk("R9 write illegal", 32'(ill), 1);
        chk("R9 write no bus", 32'(acc_d + acc_f), 0);
    endtask

    task automatic t_imm();
        pc = 32'h60; len = 4'd2;
        poke(32'h62, 32'h12AB, 2);
        op(7, 3'd4, B, 0, '0);
        chk("R10 byte imm", res, 32'hAB);
        chk("R10 byte ext", 32'(extb), 2);
        chk("R10 byte fetch size", 32'(last_fetch_size), 32'(W));
        poke(32'h62, 32'hDEADBEEF, 4);
        op(7, 3'd4, L, 0, '0);
        chk("R10 long imm", res, 32'hDEADBEEF);
        chk("R10 long ext", 32'(extb), 4);
        op(7, 3'd4, W, 1, 32'h5);
        chk("R10 write illegal", 32'(ill), 1);
        chk("R10 write no bus", 32'(acc_d + acc_f), 0);
    endtask

    task automatic t_illegal();
        set_reg(0, 3'd1, 32'h0F0F0F0F);
        op(6, 3'd1, L, 1, '1);
        chk("R11 mode6", 32'(ill), 1);
        chk("R11 mode6 ext", 32'(extb), 0);
        chk("R11 mode6 bus", 32'(acc_d + acc_f), 0);
        op(7, 3'd3, L, 0, '0); chk("R11 7/3", 32'(ill), 1);
        op(7, 3'd5, L, 0, '0); chk("R11 7/5", 32'(ill), 1);
        op(7, 3'd7, W, 0, '0); chk("R11 7/7", 32'(ill), 1);
        op(0, 3'd1, 2'd3, 1, 32'hFFFFFFFF);
        chk("R11 size3", 32'(ill), 1);
        get_reg(0, 3'd1, rv); chk("R11 D1 untouched", rv, 32'h0F0F0F0F);
        chk("R11 legal clears flag", 32'(ill), 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_indirect();
        t_postinc();
        t_predec();
        t_stack();
        t_disp();
        t_abs();
        t_pcrel();
        t_imm();
        t_illegal();
        summary();
    end

endmodule